// File: doc/BRIEF.md
# Priority Interrupt Controller with Mask, Force and Clear

This block gathers fifteen interrupt requests for a processor that has fifteen priority levels. The number of a source is also its priority, and source 15 ranks highest. A rising edge on a request input records the request in a pending register. Software can raise a request on its own through a force register. Each source passes only when its enable bit is set in the mask register. The block presents the number of the highest enabled active source as a level code, together with the matching trap type.

Software reaches four word registers through a small write bus with a combinational read port. Pending requests are removed by writing ones to a clear register. When the processor takes an interrupt it returns the level on an acknowledge input. The block then drops the pending bit for that source if one is set, and otherwise drops the forced bit.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask, pending and force registers read zero, `irq_level` is 0 and `trap_type` is 0.
- R2: `reg_addr` selects a word: 0 is the mask (read/write), 1 is pending (read-only; writes are ignored), 2 is force (read/write), and 3 is clear (write-only; it reads 0). In every register only bits 1 to 15 exist. Bit 0 and bits 16 to 31 read 0.
- R3: A mask bit of 1 lets its source reach the level output. A mask bit of 0 blocks it, whether the source is pending or forced.
- R4: `irq_level` is the highest n from 1 to 15 for which (pending[n] or force[n]) and mask[n] hold. It is 0 when there is no such n. It follows the registers in the same cycle.
- R5: `trap_type` equals 0x10 + `irq_level` when the level is non-zero, and 0 otherwise.
- R6: A 0-to-1 change of `irq_req[n]` between two clock edges sets pending[n] at the second edge. A request held high does not set the bit again after it is cleared. A set at the same edge as a clear or an acknowledge of that bit wins.
- R7: Writing a 1 to bit n of the clear register removes pending[n]. Bits written as 0 leave pending unchanged. The clear write does not affect the force register.
- R8: When `ack_valid` is high with `ack_level` = n, pending[n] is cleared if it is set, and force[n] is left alone. If pending[n] is not set, force[n] is cleared instead.
- R9: Writing the force register replaces its contents. A forced bit drives the level output exactly as a pending bit does, and writing 0 to it withdraws the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select (byte offset bits 3:2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word (combinational) |
| irq_req | input | 15 | Request inputs, bit n is source n (index 1 to 15) |
| ack_valid | input | 1 | Processor acknowledges an interrupt |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest enabled active source, 0 for none |
| trap_type | output | 8 | 0x10 + level, or 0 when idle |

## Verification
Some properties are checked on every cycle. The level code must name an enabled active source with no enabled active source above it. The trap type must carry the level in its low nibble over the 0x1 base. A detected rising edge must leave its pending bit set, even when a clear arrives at the same edge. A clear write must drop every named bit that had no rising edge. An acknowledge that hits a pending bit must leave the force register untouched. Some behaviour shows only in the bench's sweeps. These are every single source and every pair of sources under full and partial masks, the register decode, writes to the read-only word, and a request held high that does not return after a clear. They also include the two-step acknowledge that takes the pending copy first and the forced copy second.

// File: rtl/irqc_pkg.sv
// Shared types for the interrupt controller: the register word, the
// register-select encoding and the mask of bits that exist for a given
// source count. Assumes at most 31 sources in a 32-bit word.
package irqc_pkg;
    localparam int REG_W = 32;

    typedef logic [REG_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_MASK  = 2'd0,
        SEL_PEND  = 2'd1,
        SEL_FORCE = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_e;

    // Bits 1..nsrc set, all others zero.
    function automatic word_t valid_bits(input int nsrc);
        word_t m;
        m = '0;
        for (int i = 1; i < REG_W; i++) begin
            if (i <= nsrc) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irqc_regs.sv
// Software-visible mask and force registers, clear strobe decode and
// read multiplexer. Assumes one write per cycle. A force write has
// precedence over an acknowledge-driven force clear in the same cycle.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:2]  reg_addr,
    input  word_t       reg_wdata,
    input  word_t       pend_q,
    input  word_t       ack_force_clr,
    output word_t       mask_q,
    output word_t       force_q,
    output word_t       clr_strobe,
    output word_t       reg_rdata
);
    localparam word_t VALID = valid_bits(NUM_SRC);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    // Mask register: loaded by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '0;
        else if (reg_wr && sel == SEL_MASK)  mask_q <= reg_wdata & VALID;
    end

    // Force register: software write, otherwise acknowledge clears bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                          force_q <= '0;
        else if (reg_wr && sel == SEL_FORCE) force_q <= reg_wdata & VALID;
        else                                 force_q <= force_q & ~ack_force_clr;
    end

    // Clear strobe: one-cycle bit vector of pending bits to drop.
    always_comb begin
        clr_strobe = (reg_wr && sel == SEL_CLEAR) ? (reg_wdata & VALID) : '0;
    end

    // Read multiplexer; the clear word reads as zero.
    always_comb begin
        unique case (sel)
            SEL_MASK:  reg_rdata = mask_q;
            SEL_PEND:  reg_rdata = pend_q;
            SEL_FORCE: reg_rdata = force_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_pend.sv
// Per-source edge detector and pending flag. A request sets its flag on
// a 0->1 change seen at a clock edge; the set wins over a clear or an
// acknowledge of the same bit. Bit 0 and bits above NUM_SRC are tied off.
module irqc_pend
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   irq_req,
    input  word_t              clr,
    input  word_t              ack_clr,
    output word_t              pend_q,
    output word_t              rise
);
    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (g >= 1 && g <= NUM_SRC) begin : g_src
            logic req_d;
            logic pend_b;

            assign rise[g]   = irq_req[g] & ~req_d;
            assign pend_q[g] = pend_b;

            // Track the previous request level and update the pending flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    req_d  <= 1'b0;
                    pend_b <= 1'b0;
                end else begin
                    req_d  <= irq_req[g];
                    pend_b <= rise[g] | (pend_b & ~clr[g] & ~ack_clr[g]);
                end
            end
        end else begin : g_none
            assign rise[g]   = 1'b0;
            assign pend_q[g] = 1'b0;
        end
    end
endmodule

// File: rtl/irqc_prio.sv
// Priority encoder: the highest set bit among 1..NUM_SRC of the active
// vector becomes the level, and the trap type is base + level (0 if idle).
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 15,
    parameter int LVL_W     = 4,
    parameter int TRAP_BASE = 16
) (
    input  word_t              active,
    output logic [LVL_W-1:0]   level,
    output logic [7:0]         trap
);
    // Scan upward so the highest active source is kept.
    always_comb begin
        level = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i]) level = LVL_W'(i);
        end
    end

    // Trap code for the selected level.
    always_comb begin
        trap = (level == '0) ? 8'h00 : (8'(TRAP_BASE) + 8'(level));
    end
endmodule

// File: rtl/irqc_top.sv
// Interrupt controller top: joins pending, register and priority logic
// and decodes the processor acknowledge. Assumes NUM_SRC fits LVL_W bits.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 15,
    parameter int LVL_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [3:2]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC:1]   irq_req,
    input  logic               ack_valid,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [LVL_W-1:0]   irq_level,
    output logic [7:0]         trap_type
);
    word_t mask_q, force_q, pend_q, rise, clr_strobe;
    word_t ack_oh, ack_pend_clr, ack_force_clr, active;
    logic  ack_hit;

    // Acknowledge decode: drop the pending copy first, else the forced one.
    always_comb begin
        ack_hit       = ack_valid && (ack_level != '0) && (int'(ack_level) <= NUM_SRC);
        ack_oh        = word_t'(1) << ack_level;
        ack_pend_clr  = ack_hit ? (ack_oh & pend_q)  : '0;
        ack_force_clr = ack_hit ? (ack_oh & ~pend_q) : '0;
    end

    // Requests that reach the encoder.
    always_comb begin
        active = (pend_q | force_q) & mask_q;
    end

    irqc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .clr     (clr_strobe),
        .ack_clr (ack_pend_clr),
        .pend_q  (pend_q),
        .rise    (rise)
    );

    irqc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .pend_q        (pend_q),
        .ack_force_clr (ack_force_clr),
        .mask_q        (mask_q),
        .force_q       (force_q),
        .clr_strobe    (clr_strobe),
        .reg_rdata     (reg_rdata)
    );

    irqc_prio #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .TRAP_BASE(16)) u_prio (
        .active (active),
        .level  (irq_level),
        .trap   (trap_type)
    );
endmodule

// File: rtl/irqc_checker.sv
// Cycle-by-cycle properties of the interrupt controller, bound to the top.
module irqc_checker #(
    parameter int NUM_SRC = 15,
    parameter int LVL_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [3:2]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              ack_valid,
    input logic [LVL_W-1:0]  ack_level,
    input logic [LVL_W-1:0]  irq_level,
    input logic [7:0]        trap_type,
    input logic [31:0]       mask_q,
    input logic [31:0]       pend_q,
    input logic [31:0]       force_q,
    input logic [31:0]       rise
);
    logic [31:0] act, ack_oh;
    assign act    = (pend_q | force_q) & mask_q;
    assign ack_oh = 32'd1 << ack_level;

    // R4: a non-zero level names an enabled active source
    p_level_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> act[irq_level]);

    // R4: nothing enabled and active sits above the level
    p_level_highest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((act >> irq_level) >> 1) == 32'd0);

    // R5: trap code carries the level over the 0x1 base nibble
    p_trap_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (trap_type[3:0] == 4'(irq_level) && trap_type[7:4] == 4'h1));

    // R5: idle level gives a zero trap code
    p_trap_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (trap_type == 8'h00));

    // R6: a detected edge leaves its pending bit set
    p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != 32'd0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R7: clear drops named bits that saw no edge
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3) |=> ((pend_q & $past(reg_wdata) & ~$past(rise)) == 32'd0));

    // R8: acknowledge of a pending source leaves force alone
    p_ack_keeps_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && (ack_oh & pend_q) != 32'd0 && !(reg_wr && reg_addr == 2'd2))
        |=> $stable(force_q));

    // R2: bit 0 never reads as set
    p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] == 1'b0);
endmodule

bind irqc_top irqc_checker #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .irq_level (irq_level),
    .trap_type (trap_type),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .force_q   (force_q),
    .rise      (rise)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
    localparam logic [31:0] VALID = 32'h0000_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:2]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [15:1] irq_req = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = 4'd0;
    logic [3:0]  irq_level;
    logic [7:0]  trap_type;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_mask = 0, m_pend = 0, m_force = 0;

    irqc_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .ack_valid(ack_valid), .ack_level(ack_level),
        .irq_level(irq_level), .trap_type(trap_type)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Expected level and trap from the model registers.
    task automatic out_chk(input string tag);
        logic [31:0] act;
        int lvl;
        act = (m_pend | m_force) & m_mask;
        lvl = 0;
        for (int i = 1; i <= 15; i++) if (act[i]) lvl = i;
        chk({tag, " level"}, 32'(irq_level), 32'(lvl));
        chk({tag, " trap"}, 32'(trap_type), (lvl == 0) ? 32'd0 : 32'(16 + lvl));
    endtask

    task automatic pulse(input int n);
        @(negedge clk); irq_req[n] = 1'b1;
        @(negedge clk); irq_req[n] = 1'b0;
        m_pend[n] = 1'b1;
    endtask

    task automatic ack(input int n);
        @(negedge clk); ack_valid = 1'b1; ack_level = 4'(n);
        @(negedge clk); ack_valid = 1'b0;
        if (m_pend[n]) m_pend[n] = 1'b0; else m_force[n] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        out_chk("R1");
        rd_chk("R1 mask", 2'd0, 0);
        rd_chk("R1 pend", 2'd1, 0);
        rd_chk("R1 force", 2'd2, 0);

        // R2: decode, unused bits, read-only pending, clear reads zero
        wr(2'd0, 32'hFFFF_FFFF); m_mask = VALID;
        rd_chk("R2 mask bits", 2'd0, VALID);
        wr(2'd1, 32'hFFFF_FFFF);
        rd_chk("R2 pend write ignored", 2'd1, 0);
        out_chk("R2 pend write ignored");
        rd_chk("R2 clear reads zero", 2'd3, 0);

        // R9 R3 R4 R5: every single forced source, enabled then masked
        for (int n = 1; n <= 15; n++) begin
            wr(2'd2, 32'd1 << n); m_force = (32'd1 << n);
            rd_chk("R9 force readback", 2'd2, m_force);
            out_chk("R9 R5 single");
            wr(2'd0, VALID & ~(32'd1 << n)); m_mask = VALID & ~(32'd1 << n);
            out_chk("R3 masked single");
            wr(2'd0, VALID); m_mask = VALID;
        end

        // R4: every pair, highest wins; masking the top exposes the lower
        for (int i = 1; i <= 14; i++) begin
            for (int j = i + 1; j <= 15; j++) begin
                wr(2'd2, (32'd1 << i) | (32'd1 << j)); m_force = (32'd1 << i) | (32'd1 << j);
                out_chk("R4 pair");
                wr(2'd0, VALID & ~(32'd1 << j)); m_mask = VALID & ~(32'd1 << j);
                out_chk("R4 R3 pair masked");
                wr(2'd0, VALID); m_mask = VALID;
            end
        end
        wr(2'd2, 0); m_force = 0;
        out_chk("R9 force withdrawn");

        // R6: edge on every source sets pending
        for (int n = 1; n <= 15; n++) begin
            pulse(n);
            rd_chk("R6 pend after pulse", 2'd1, m_pend);
            out_chk("R6 pulse");
        end

        // R7: zero bits have no effect, ones remove
        wr(2'd3, 0);
        rd_chk("R7 zero clear", 2'd1, m_pend);
        wr(2'd3, 32'h0000_5554); m_pend = m_pend & ~32'h0000_5554;
        rd_chk("R7 partial clear", 2'd1, m_pend);
        out_chk("R7 partial clear");
        wr(2'd3, 32'hFFFF_FFFF); m_pend = 0;
        rd_chk("R7 full clear", 2'd1, 0);

        // R3: pending source blocked by mask
        pulse(2); pulse(12);
        wr(2'd0, VALID & ~(32'd1 << 12)); m_mask = VALID & ~(32'd1 << 12);
        out_chk("R3 pending masked");
        wr(2'd0, VALID); m_mask = VALID;
        wr(2'd3, VALID); m_pend = 0;

        // R6: held request does not re-set after clear
        @(negedge clk); irq_req[5] = 1'b1;
        @(negedge clk); m_pend[5] = 1'b1;
        rd_chk("R6 held set", 2'd1, m_pend);
        wr(2'd3, 32'd1 << 5); m_pend = 0;
        @(negedge clk);
        rd_chk("R6 held no reset", 2'd1, 0);
        out_chk("R6 held");
        irq_req[5] = 1'b0;

        // R6: set and clear at the same edge, set wins
        @(negedge clk);
        irq_req[7] = 1'b1; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'd1 << 7;
        @(negedge clk);
        reg_wr = 1'b0; irq_req[7] = 1'b0; m_pend[7] = 1'b1;
        rd_chk("R6 set beats clear", 2'd1, m_pend);
        wr(2'd3, VALID); m_pend = 0;

        // R8: acknowledge takes pending first, then force
        pulse(9);
        wr(2'd2, 32'd1 << 9); m_force = 32'd1 << 9;
        out_chk("R8 before ack");
        ack(9);
        rd_chk("R8 pend dropped", 2'd1, 0);
        rd_chk("R8 force kept", 2'd2, 32'd1 << 9);
        out_chk("R8 after first ack");
        ack(9);
        rd_chk("R8 force dropped", 2'd2, 0);
        out_chk("R8 after second ack");

        // R8: acknowledge of one level leaves others
        pulse(3); pulse(14);
        ack(14);
        rd_chk("R8 other kept", 2'd1, 32'd1 << 3);
        out_chk("R8 other kept");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule